// File: doc/BRIEF.md
# Scan-Mode ADC Channel Sequencer

This block drives an analog-to-digital converter that samples a small group of multiplexer inputs over and over. Software loads a configuration word: a run bit, a bit that picks one of two channel groups, a two-bit field that sets how many channels of the group take part, and an interrupt enable. A timer can also set the run bit through a trigger pin. While running, the sequencer pulses a start request to the converter with the channel index on a separate bus. It waits for the converter's done strobe and its 10-bit result, files the result in the register for that channel, and moves straight on to the next channel.

When the last channel of the group finishes, a sticky pass-complete flag is raised. The scan then wraps to the group's first channel. An interrupt line follows the flag when enabled. Clearing the run bit halts the scan at once and discards the conversion in flight. Running again always begins at the group's first channel. Stored results are read through a combinational read port.

The converter's result path is a valid-only stream: `conv_done` marks a valid `conv_data`. There is no ready, because a request is issued only when the block can take the answer. Every strobe that arrives while a conversion is pending is accepted. Strobes that arrive at any other time are dropped.

Top module: `scan_adc_seq`

## Requirements
- R1: After reset the run bit, the pass-complete flag, the interrupt, the start request and every result register are 0.
- R2: A configuration write with the run bit at 1, or a pulse on `trig_in` while stopped, starts a scan. The first request targets channel `{cfg_group, 2'b00}`, so group 0 starts at channel 0 and group 1 starts at channel 4. Group, count and enable from that same write already apply to the first request.
- R3: The count field sets how many consecutive channels of the group are converted: 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 4. Channels are visited in ascending order from the group's first channel.
- R4: `conv_start` is a one-cycle pulse. The next request is raised in the cycle after the done strobe is accepted, with no software action, so with a converter latency of L cycles the requests are L+1 cycles apart.
- R5: An accepted `conv_data` is stored in the result register of the channel that was requested, and `rd_data` shows the register selected by `rd_ch`.
- R6: When the last counted channel completes, `end_flag` becomes 1 and the next request wraps to the group's first channel. Scanning continues while the run bit stays 1. The flag is never set except after an accepted done strobe.
- R7: `irq` equals `end_flag` AND the interrupt enable bit.
- R8: `end_flag` holds at 1 until `flag_clr` is pulsed. A pass end in the same cycle as a clear wins.
- R9: A configuration write with the run bit at 0 stops the scan and aborts any conversion in flight. The later done strobe is ignored, no result register changes, and no request is raised while stopped. The write wins over a done strobe in the same cycle.
- R10: Starting again after a stop always begins at the group's first channel, whatever channel was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe; loads the four cfg fields |
| cfg_start | input | 1 | Run bit value to write |
| cfg_group | input | 1 | Group select to write |
| cfg_count | input | 2 | Channel count field to write (count minus one) |
| cfg_ie | input | 1 | Interrupt enable to write |
| trig_in | input | 1 | Timer trigger; sets the run bit |
| flag_clr | input | 1 | Clears the pass-complete flag |
| running | output | 1 | Current run bit |
| end_flag | output | 1 | Sticky pass-complete flag |
| irq | output | 1 | Interrupt request |
| conv_start | output | 1 | Conversion request pulse |
| conv_ch | output | 3 | Channel to convert, valid with `conv_start` |
| conv_done | input | 1 | Result valid strobe from converter |
| conv_data | input | 10 | Conversion result |
| rd_ch | input | 3 | Result register select |
| rd_data | output | 10 | Selected result register |

## Verification
The bench builds the block with its defaults: two groups, a two-bit count field and 10-bit results. It pairs the block with a converter model that answers three cycles after each request. Both groups and all four count codes are within reach, including the single-channel scan that wraps on every conversion and the full four-channel group. The fixed latency makes the four-cycle request spacing exact. A stop issued between request and answer lands an abort deterministically inside the pending window.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/scan_ctrl_regs.sv
module scan_ctrl_regs #(
  parameter int CNT_W  = 2,
  parameter int GSEL_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_start,
  input  logic [GSEL_W-1:0] cfg_group,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_ie,
  input  logic              trig_in,
  input  logic              flag_clr,
  input  logic              pass_end,
  output logic              run_q,
  output logic [GSEL_W-1:0] grp_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ie_q,
  output logic              flag_q,
  output logic              stop_now
);
  // a write with the run bit low halts the sequencer in this very cycle
  assign stop_now = cfg_we && !cfg_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      grp_q <= '0;
      cnt_q <= '0;
      ie_q  <= 1'b0;
    end else if (cfg_we) begin
      run_q <= cfg_start;
      grp_q <= cfg_group;
      cnt_q <= cfg_count;
      ie_q  <= cfg_ie;
    end else if (trig_in) begin
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (pass_end) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int GSEL_W = 1,
  localparam int CH_W  = GSEL_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_q,
  input  logic              stop_now,
  input  logic [GSEL_W-1:0] grp_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              conv_done,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  output logic              wr_en,
  output logic [CH_W-1:0]   wr_ch,
  output logic              pass_end
);
  sq_state_t        state;
  logic [CNT_W-1:0] idx;
  logic [CH_W-1:0]  cur_ch;
  logic             last;

  assign last       = (idx == cnt_q);
  assign conv_start = (state == SQ_ISSUE);
  assign conv_ch    = {grp_q, idx};
  assign wr_en      = (state == SQ_WAIT) && conv_done && run_q && !stop_now;
  assign wr_ch      = cur_ch;
  assign pass_end   = wr_en && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      idx    <= '0;
      cur_ch <= '0;
    end else if (!run_q || stop_now) begin
      state <= SQ_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          state <= SQ_ISSUE;
          idx   <= '0;
        end
        SQ_ISSUE: begin
          cur_ch <= conv_ch;
          state  <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (conv_done) begin
            state <= SQ_ISSUE;
            idx   <= last ? '0 : idx + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_result_bank.sv
module scan_result_bank #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [RES_W-1:0] wr_data,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [RES_W-1:0] rd_data
);
  logic [RES_W-1:0] bank [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             bank[g] <= '0;
      else if (wr_en && wr_ch == CH_W'(g))    bank[g] <= wr_data;
    end
  end

  assign rd_data = bank[rd_ch];
endmodule

// File: rtl/scan_adc_seq.sv
module scan_adc_seq #(
  parameter int NUM_GRP = 2,
  parameter int CNT_W   = 2,
  parameter int RES_W   = 10,
  localparam int GSEL_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int CH_W   = GSEL_W + CNT_W,
  localparam int NUM_CH = 1 << CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_start,
  input  logic [GSEL_W-1:0] cfg_group,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_ie,
  input  logic              trig_in,
  input  logic              flag_clr,
  output logic              running,
  output logic              end_flag,
  output logic              irq,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [RES_W-1:0]  rd_data
);
  logic              run_q, ie_q, stop_now, pass_end, wr_en;
  logic [GSEL_W-1:0] grp_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CH_W-1:0]   wr_ch;

  scan_ctrl_regs #(.CNT_W(CNT_W), .GSEL_W(GSEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_start(cfg_start),
    .cfg_group(cfg_group), .cfg_count(cfg_count), .cfg_ie(cfg_ie),
    .trig_in(trig_in), .flag_clr(flag_clr), .pass_end(pass_end),
    .run_q(run_q), .grp_q(grp_q), .cnt_q(cnt_q), .ie_q(ie_q),
    .flag_q(end_flag), .stop_now(stop_now)
  );

  scan_sequencer #(.CNT_W(CNT_W), .GSEL_W(GSEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .stop_now(stop_now),
    .grp_q(grp_q), .cnt_q(cnt_q), .conv_done(conv_done),
    .conv_start(conv_start), .conv_ch(conv_ch), .wr_en(wr_en),
    .wr_ch(wr_ch), .pass_end(pass_end)
  );

  scan_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_data(conv_data), .rd_ch(rd_ch), .rd_data(rd_data)
  );

  assign running = run_q;
  assign irq     = end_flag && ie_q;
endmodule

// File: rtl/scan_adc_seq_chk.sv
module scan_adc_seq_chk #(
  parameter int CH_W   = 3,
  parameter int GSEL_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              running,
  input logic              end_flag,
  input logic              flag_clr,
  input logic              conv_start,
  input logic              conv_done,
  input logic [CH_W-1:0]   conv_ch,
  input logic [GSEL_W-1:0] grp_q
);
  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !conv_start);

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flag && !flag_clr) |=> end_flag);

  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!end_flag && !conv_done) |=> !end_flag);

  assert_in_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_ch[CH_W-1 -: GSEL_W] == grp_q));
endmodule

bind scan_adc_seq scan_adc_seq_chk #(.CH_W(CH_W), .GSEL_W(GSEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .end_flag(end_flag),
  .flag_clr(flag_clr), .conv_start(conv_start), .conv_done(conv_done),
  .conv_ch(conv_ch), .grp_q(grp_q)
);

// File: tb/scan_adc_seq_tb.sv
module scan_adc_seq_tb;
  localparam int LAT = 3;
  // vector: [9] group, [8:7] count, [6] ie, [5:3] first channel, [2:0] channels
  localparam logic [9:0] VEC [4] = '{
    {1'b0, 2'd2, 1'b1, 3'd0, 3'd3},
    {1'b1, 2'd0, 1'b0, 3'd4, 3'd1},
    {1'b1, 2'd3, 1'b1, 3'd4, 3'd4},
    {1'b0, 2'd1, 1'b0, 3'd0, 3'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_start = 0, cfg_group = 0, cfg_ie = 0, trig_in = 0, flag_clr = 0;
  logic [1:0] cfg_count = 0;
  logic running, end_flag, irq, conv_start, conv_done = 0;
  logic [2:0] conv_ch, rd_ch = 0;
  logic [9:0] conv_data = 0, rd_data;

  int total = 0, bad = 0;
  int last_data [8];
  bit accept = 0;

  always #2 clk = ~clk;

  scan_adc_seq u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: answers LAT cycles after a request
  initial begin
    int cnt = 0, seq = 0, ch = 0;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        cnt = LAT; ch = conv_ch; conv_done = 0;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          seq++;
          conv_data = {ch[2:0], seq[6:0]};
          conv_done = 1;
          if (accept) last_data[ch] = conv_data;
        end else conv_done = 0;
      end else conv_done = 0;
    end
  end

  task automatic wr(input bit st, input bit g, input logic [1:0] c, input bit ie);
    @(negedge clk);
    if (!st) accept = 0;
    cfg_we = 1; cfg_start = st; cfg_group = g; cfg_count = c; cfg_ie = ie;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clr_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic wait_issue(output int ch, output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!conv_start);
    ch = conv_ch;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ch, gap, pre, n, base, qc;
    foreach (last_data[i]) last_data[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!running && !end_flag && !irq && !conv_start, "R1", {running, end_flag, irq, conv_start}, 0);
    for (int i = 0; i < 8; i++) begin
      rd_ch = 3'(i); #1;
      chk(rd_data == 0, "R1", rd_data, 0);
    end
    rst_n = 1;

    // table walk: each write changes settings and starts at once
    for (int v = 0; v < 4; v++) begin
      base = VEC[v][5:3]; n = VEC[v][2:0];
      clr_flag();
      accept = 1;
      wr(1, VEC[v][9], VEC[v][8:7], VEC[v][6]);
      wait_issue(ch, gap);
      chk(ch == base, "R2", ch, base);
      for (int k = 1; k <= 2 * n; k++) begin
        wait_issue(ch, gap);
        chk(ch == base + (k % n), "R3", ch, base + (k % n));
        chk(gap == LAT + 1, "R4", gap, LAT + 1);
        if (k == n - 1) chk(!end_flag, "R6", end_flag, 0);
        if (k == n) begin
          chk(end_flag, "R6", end_flag, 1);
          chk(irq == VEC[v][6], "R7", irq, VEC[v][6]);
        end
      end
      wr(0, VEC[v][9], VEC[v][8:7], VEC[v][6]);
      repeat (8) @(negedge clk);
      for (int c = 0; c < n; c++) begin
        rd_ch = 3'(base + c); #1;
        chk(rd_data == 10'(last_data[base + c]), "R5", rd_data, last_data[base + c]);
      end
    end

    // R2: trigger start, group 1, two channels, interrupt enabled
    clr_flag();
    wr(0, 1, 2'd1, 1);
    accept = 1;
    @(negedge clk); trig_in = 1;
    @(negedge clk); trig_in = 0;
    wait_issue(ch, gap);
    chk(ch == 4, "R2", ch, 4);
    wait_issue(ch, gap);
    wait_issue(ch, gap);
    chk(ch == 4 && end_flag, "R6", {ch, end_flag}, 9);

    // R9: abort mid conversion
    rd_ch = 3'd4; #1; pre = rd_data;
    wr(0, 1, 2'd1, 1);
    qc = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (conv_start) qc++; end
    chk(qc == 0, "R9", qc, 0);
    #1; chk(rd_data == 10'(pre), "R9", rd_data, pre);
    chk(!running, "R9", running, 0);
    chk(end_flag && irq, "R8", {end_flag, irq}, 3);

    // R10: restart after stop mid pass
    accept = 1;
    wr(1, 1, 2'd1, 1);
    wait_issue(ch, gap);
    wait_issue(ch, gap);
    chk(ch == 5, "R3", ch, 5);
    wr(0, 1, 2'd1, 1);
    accept = 1;
    wr(1, 1, 2'd1, 1);
    wait_issue(ch, gap);
    chk(ch == 4, "R10", ch, 4);
    wr(0, 1, 2'd1, 1);
    repeat (6) @(negedge clk);

    // R7 / R8: enable off masks irq, clear drops flag
    wr(0, 1, 2'd1, 0);
    #1;
    chk(end_flag && !irq, "R7", {end_flag, irq}, 2);
    clr_flag();
    #1;
    chk(!end_flag, "R8", end_flag, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule